// File: doc/BRIEF.md
# Three-Wire Register Configuration Master

This block runs single-register write and read transactions over a three-wire configuration port. The port has an active-low address-latch enable, a serial clock and one data line. The data line is shared by both directions. At its edge it appears as an output value, an output-enable and an input value, so that a pad cell can join them.

A host loads a 7-bit register address, a direction flag and, for writes, a data byte, and then pulses a start strobe. The master frames the address and direction under the latch enable. It then moves one byte in the data phase. On reads it releases the line before the target drives it. When the transaction ends it raises a one-cycle done pulse, and for reads the returned byte stays on the read-data output.

The serial clock is derived from the system clock. Each low half and each high half lasts a parameterised number of system cycles.

Top module: `cfgwire_master`

## Requirements
- R1: While busy_o is low, ale_n_o, sclk_o and sdata_o are 1 and sdata_oe_o is 1. After reset, busy_o and done_o are 0.
- R2: ale_n_o is low for exactly the first 8 falling edges of sclk_o in a transaction. It rises while sclk_o is high and stays high for the rest of the transaction.
- R3: At the 8 address-phase falling edges, sdata_o carries addr_i[6] down to addr_i[0], then a direction bit: 1 for a write (rd_i=0) and 0 for a read (rd_i=1).
- R4: sdata_o changes only while sclk_o is high. While the line is driven and sclk_o stays low, its value holds.
- R5: A write makes 16 falling edges of sclk_o. The last 8 carry wdata_i[7] down to wdata_i[0] on sdata_o.
- R6: sdata_oe_o is 1 for the whole address phase, including the direction bit. On a read it is 0 at each of the 8 data-phase falling edges, and at no point of a write.
- R7: On a read, the master takes sdata_i while sclk_o is low after each of 8 falling edges, most significant bit first. When done_o is seen, rdata_o holds that byte.
- R8: During a transaction, every low interval of sclk_o and every high interval between two falling edges lasts at least HALF_CYCLES system cycles.
- R9: A start_i that arrives while busy_o is 1 is ignored, including in the done_o cycle. The running frame is unchanged and no second frame follows.
- R10: done_o is high for exactly one cycle per transaction, and busy_o is high in that cycle. rdata_o changes only while busy_o is high.
- R11: A synchronous reset that is asserted in the middle of a transaction returns every line to the R1 idle levels in the next cycle, and the next transaction runs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| rd_i | input | 1 | 1 = read transaction, 0 = write |
| addr_i | input | 7 | Register address |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Byte returned by the last read |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| ale_n_o | output | 1 | Address-latch enable, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Data line output value |
| sdata_oe_o | output | 1 | Data line output enable, 1 = driven |
| sdata_i | input | 1 | Data line input value |

## Verification
The end of one transaction can coincide with a request for the next. The done pulse and a new start strobe fall in the same system cycle. The bench watches done_o at mid-cycle and raises start_i in that same cycle, so the strobe reaches the edge where the master leaves its final phase. It then checks that busy_o drops and that no further falling edge appears on the serial clock. It also presses start on a frame that is still running and confirms that the captured address, direction and data belong only to the first request.

// File: rtl/cfgwire_pkg.sv
package cfgwire_pkg;

    // Field widths of the transaction
    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned FRAME_W = ADDR_W + 1;
    localparam int unsigned SHIFT_W = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
    localparam int unsigned BIT_W   = $clog2(SHIFT_W);

    // Phases of one transaction
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_TURN = 3'd2,
        PH_DATA = 3'd3,
        PH_FIN  = 3'd4
    } phase_e;

    // Sequencer state
    typedef struct packed {
        phase_e           phase;
        logic             low;      // 1 while in the low half of a bit
        logic [BIT_W-1:0] bitno;    // bit index within current phase
        logic             is_read;
    } seq_t;

    // Request captured at start
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic [DATA_W-1:0] wdata;
    } req_t;

    localparam seq_t SEQ_IDLE = '{phase: PH_IDLE, low: 1'b0, bitno: '0, is_read: 1'b0};

    // Address frame: address bits then direction (1 = write)
    function automatic logic [SHIFT_W-1:0] addr_frame(input logic [ADDR_W-1:0] a,
                                                      input logic rd);
        logic [SHIFT_W-1:0] f;
        f = '0;
        f[SHIFT_W-1 -: FRAME_W] = {a, ~rd};
        return f;
    endfunction

    // Data byte aligned to the shift-out end
    function automatic logic [SHIFT_W-1:0] data_frame(input logic [DATA_W-1:0] d);
        logic [SHIFT_W-1:0] f;
        f = '0;
        f[SHIFT_W-1 -: DATA_W] = d;
        return f;
    endfunction

    // Last bit index of a phase
    function automatic logic last_bit(input phase_e ph, input logic [BIT_W-1:0] b);
        logic r;
        case (ph)
            PH_ADDR: r = (b == BIT_W'(FRAME_W - 1));
            PH_DATA: r = (b == BIT_W'(DATA_W - 1));
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Phases in which the serial clock toggles
    function automatic logic clocked_phase(input phase_e ph);
        return (ph == PH_ADDR) || (ph == PH_DATA);
    endfunction

endpackage

// File: rtl/cfgwire_halftimer.sv
module cfgwire_halftimer #(
    parameter int unsigned HALF_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int unsigned EFF = (HALF_CYCLES < 1) ? 1 : HALF_CYCLES;

    generate
        if (EFF == 1) begin : g_every
            assign expire = run;
        end else begin : g_count
            localparam int unsigned CW = $clog2(EFF);
            localparam logic [CW-1:0] LAST = CW'(EFF - 1);
            logic [CW-1:0] cnt_q;

            assign expire = run && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run || expire) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cfgwire_shifter.sv
module cfgwire_shifter #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             shift_in,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[WIDTH-2:0], shift_in};
        end
    end
endmodule

// File: rtl/cfgwire_master.sv
module cfgwire_master
    import cfgwire_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ale_n_o,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sdata_oe_o,
    input  logic              sdata_i
);
    seq_t seq_q, seq_d;
    req_t req_q;
    logic tick;
    logic accept;

    logic               tx_load;
    logic [SHIFT_W-1:0] tx_load_val;
    logic               tx_shift;
    logic [SHIFT_W-1:0] tx_q;
    logic               rx_shift;

    assign accept = start_i && (seq_q.phase == PH_IDLE);

    // Half-period timer of the serial clock
    cfgwire_halftimer #(.HALF_CYCLES(HALF_CYCLES)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (seq_q.phase != PH_IDLE),
        .expire (tick)
    );

    // Outgoing shift register (address frame, then write byte)
    cfgwire_shifter #(.WIDTH(SHIFT_W), .RST_VAL({SHIFT_W{1'b1}})) i_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (tx_load),
        .load_val (tx_load_val),
        .shift    (tx_shift),
        .shift_in (1'b1),
        .q        (tx_q)
    );

    // Incoming shift register, doubles as the read-data output
    cfgwire_shifter #(.WIDTH(DATA_W), .RST_VAL('0)) i_rx (
        .clk      (clk),
        .rst      (rst),
        .load     (1'b0),
        .load_val ('0),
        .shift    (rx_shift),
        .shift_in (sdata_i),
        .q        (rdata_o)
    );

    // Request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= '{addr: addr_i, rd: rd_i, wdata: wdata_i};
        end
    end

    // Sequencer next state
    always_comb begin
        seq_d       = seq_q;
        tx_load     = 1'b0;
        tx_load_val = data_frame(req_q.wdata);
        tx_shift    = 1'b0;
        rx_shift    = 1'b0;

        case (seq_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    seq_d       = '{phase: PH_ADDR, low: 1'b0, bitno: '0, is_read: rd_i};
                    tx_load     = 1'b1;
                    tx_load_val = addr_frame(addr_i, rd_i);
                end
            end
            PH_ADDR, PH_DATA: begin
                if (tick) begin
                    if (!seq_q.low) begin
                        seq_d.low = 1'b1;
                    end else begin
                        seq_d.low = 1'b0;
                        if (seq_q.phase == PH_DATA && seq_q.is_read) begin
                            rx_shift = 1'b1;
                        end
                        if (last_bit(seq_q.phase, seq_q.bitno)) begin
                            seq_d.bitno = '0;
                            if (seq_q.phase == PH_ADDR) begin
                                tx_load     = 1'b1;
                                seq_d.phase = seq_q.is_read ? PH_TURN : PH_DATA;
                            end else begin
                                seq_d.phase = PH_FIN;
                            end
                        end else begin
                            seq_d.bitno = seq_q.bitno + 1'b1;
                            tx_shift    = 1'b1;
                        end
                    end
                end
            end
            PH_TURN: begin
                if (tick) begin
                    seq_d.phase = PH_DATA;
                end
            end
            PH_FIN: begin
                if (tick) begin
                    seq_d = SEQ_IDLE;
                end
            end
            default: seq_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Pin levels, all decoded from registered state
    logic drive_bits;
    logic released;

    assign drive_bits = (seq_q.phase == PH_ADDR) ||
                        (seq_q.phase == PH_DATA && !seq_q.is_read);
    assign released   = seq_q.is_read &&
                        (seq_q.phase == PH_TURN || seq_q.phase == PH_DATA);

    assign busy_o     = (seq_q.phase != PH_IDLE);
    assign done_o     = (seq_q.phase == PH_FIN) && tick;
    assign ale_n_o    = (seq_q.phase != PH_ADDR);
    assign sclk_o     = !(clocked_phase(seq_q.phase) && seq_q.low);
    assign sdata_o    = drive_bits ? tx_q[SHIFT_W-1] : 1'b1;
    assign sdata_oe_o = !released;

endmodule

// File: rtl/cfgwire_master_chk.sv
module cfgwire_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_o,
    input logic       done_o,
    input logic       ale_n_o,
    input logic       sclk_o,
    input logic       sdata_o,
    input logic       sdata_oe_o,
    input logic [7:0] rdata_o
);
    // R1: idle levels
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (ale_n_o && sclk_o && sdata_o && sdata_oe_o));

    // R2: latch enable rises only while the clock is high
    p_ale_rise_high_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ale_n_o) |-> sclk_o);

    // R4: driven data holds while the clock stays low
    p_data_hold_low_r4: assert property (@(posedge clk) disable iff (rst)
        (!sclk_o && $past(!sclk_o) && sdata_oe_o) |-> $stable(sdata_o));

    // R6: line is driven throughout the address phase
    p_addr_driven_r6: assert property (@(posedge clk) disable iff (rst)
        !ale_n_o |-> sdata_oe_o);

    // R10: done is a single cycle inside busy
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(rdata_o));

    // R11: first cycle after reset is idle
    p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !done_o));
endmodule

bind cfgwire_master cfgwire_master_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ale_n_o    (ale_n_o),
    .sclk_o     (sclk_o),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .rdata_o    (rdata_o)
);

// File: tb/test_cfgwire_master.sv
`timescale 1ns/1ps
module test_cfgwire_master;
    localparam int H = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [6:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       busy_o, done_o, ale_n_o, sclk_o, sdata_o, sdata_oe_o;
    logic       sdata_i = 1'b1;

    always #2.5 clk = ~clk;

    cfgwire_master #(.HALF_CYCLES(H)) i_cfgwire_master (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .busy_o(busy_o), .done_o(done_o), .ale_n_o(ale_n_o),
        .sclk_o(sclk_o), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
        .sdata_i(sdata_i)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Monitor / target model state
    logic prev_sclk = 1'b1, prev_sdo = 1'b1, prev_done = 1'b0, seen_rise = 1'b0;
    logic cur_rd = 1'b0;
    logic [7:0] tgt_byte = '0;
    logic [7:0] addr_sh, data_sh;
    int run_len = 0, n_fall = 0, n_ale_fall = 0, late_ale = 0, rbit = 0;
    int oe_err = 0, width_err = 0, idle_err = 0, stable_err = 0;
    int n_done = 0, done_wide = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_fall = 0; n_ale_fall = 0; late_ale = 0; rbit = 0;
        oe_err = 0; width_err = 0; idle_err = 0; stable_err = 0;
        n_done = 0; done_wide = 0; seen_rise = 1'b0;
        addr_sh = '0; data_sh = '0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!busy_o && !(ale_n_o && sclk_o && sdata_o && sdata_oe_o)) idle_err++;
            if (done_o) begin
                n_done++;
                if (prev_done) done_wide++;
            end
            if (!sclk_o && !prev_sclk && sdata_oe_o && sdata_o != prev_sdo) stable_err++;
            if (sclk_o != prev_sclk) begin
                if (!prev_sclk) begin
                    if (run_len < H) width_err++;
                    seen_rise = 1'b1;
                end else if (seen_rise && run_len < H) begin
                    width_err++;
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            if (prev_sclk && !sclk_o) begin
                n_fall++;
                if (!ale_n_o) begin
                    n_ale_fall++;
                    if (n_fall > n_ale_fall) late_ale++;
                    addr_sh = {addr_sh[6:0], sdata_o};
                    if (!sdata_oe_o) oe_err++;
                end else if (sdata_oe_o) begin
                    data_sh = {data_sh[6:0], sdata_o};
                    if (cur_rd) oe_err++;
                end else begin
                    sdata_i = tgt_byte[3'(7 - rbit)];
                    rbit++;
                    if (!cur_rd) oe_err++;
                end
            end
            prev_sclk = sclk_o;
            prev_sdo  = sdata_o;
            prev_done = done_o;
        end else begin
            prev_sclk = 1'b1; prev_sdo = 1'b1; prev_done = 1'b0; run_len = 0;
        end
    end

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy_o) begin ok = 1'b1; break; end
        end
    endtask

    task automatic launch(input logic [6:0] a, input logic rd,
                          input logic [7:0] wd, input logic [7:0] tg);
        @(negedge clk);
        clear_mon();
        cur_rd = rd; tgt_byte = tg;
        addr_i = a; rd_i = rd; wdata_i = wd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic judge(input logic [6:0] a, input logic rd,
                         input logic [7:0] wd, input logic [7:0] tg);
        chk(n_ale_fall == 8 && late_ale == 0, "R2", "latch-enable pulses", n_ale_fall, 8);
        chk(addr_sh == {a, ~rd}, "R3", "address frame", addr_sh, {a, ~rd});
        chk(stable_err == 0, "R4", "data moved while clock low", stable_err, 0);
        chk(n_fall == 16, "R5", "falling edges", n_fall, 16);
        if (!rd) chk(data_sh == wd, "R5", "write byte", data_sh, wd);
        chk(oe_err == 0, "R6", "output-enable errors", oe_err, 0);
        if (rd) chk(rdata_o == tg, "R7", "read byte", rdata_o, tg);
        chk(width_err == 0, "R8", "short clock halves", width_err, 0);
        chk(idle_err == 0, "R1", "idle level errors", idle_err, 0);
        chk(n_done == 1 && done_wide == 0, "R10", "done pulses", n_done, 1);
    endtask

    task automatic run_txn(input logic [6:0] a, input logic rd,
                           input logic [7:0] wd, input logic [7:0] tg);
        bit ok;
        launch(a, rd, wd, tg);
        wait_idle(ok);
        chk(ok, "R10", "transaction finished", int'(ok), 1);
        judge(a, rd, wd, tg);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit ok;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o, "R1", "busy/done after reset", {busy_o, done_o}, 0);
        chk(ale_n_o && sclk_o && sdata_o && sdata_oe_o, "R1", "idle lines",
            {ale_n_o, sclk_o, sdata_o, sdata_oe_o}, 15);

        // Sweep all addresses: writes then reads
        for (int a = 0; a < 128; a++)
            run_txn(7'(a), 1'b0, 8'(a * 37 + 5), 8'h00);
        for (int a = 0; a < 128; a++)
            run_txn(7'(a), 1'b1, 8'h00, 8'(a * 53) ^ 8'hA5);
        run_txn(7'h7F, 1'b0, 8'hFF, 8'h00);
        run_txn(7'h00, 1'b0, 8'h00, 8'h00);
        run_txn(7'h55, 1'b1, 8'h00, 8'hFF);
        run_txn(7'h2A, 1'b1, 8'h00, 8'h00);

        // R10: rdata holds across a following write
        run_txn(7'h11, 1'b1, 8'h00, 8'h3C);
        held = rdata_o;
        run_txn(7'h22, 1'b0, 8'hC3, 8'h00);
        repeat (5) @(negedge clk);
        chk(rdata_o == held, "R10", "read data held", rdata_o, held);

        // R9: start while mid-frame is ignored
        launch(7'h4B, 1'b0, 8'h96, 8'h00);
        repeat (20) @(negedge clk);
        addr_i = 7'h12; rd_i = 1'b1; wdata_i = 8'h01; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle(ok);
        judge(7'h4B, 1'b0, 8'h96, 8'h00);
        chk(addr_sh == {7'h4B, 1'b1}, "R9", "frame unchanged by late start", addr_sh, {7'h4B, 1'b1});

        // R9: start in the done cycle is ignored
        launch(7'h30, 1'b0, 8'h5A, 8'h00);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done_o) break;
        end
        addr_i = 7'h31; rd_i = 1'b0; wdata_i = 8'h77; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R9", "busy after start in done cycle", busy_o, 0);
        repeat (20) @(negedge clk);
        chk(n_fall == 16 && !busy_o, "R9", "no second frame", n_fall, 16);
        chk(data_sh == 8'h5A, "R5", "write byte before coincident start", data_sh, 8'h5A);

        // R11: reset mid-transaction
        launch(7'h66, 1'b1, 8'h00, 8'h81);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && !done_o, "R11", "busy/done after mid reset", {busy_o, done_o}, 0);
        chk(ale_n_o && sclk_o && sdata_o && sdata_oe_o, "R11", "lines after mid reset",
            {ale_n_o, sclk_o, sdata_o, sdata_oe_o}, 15);
        run_txn(7'h19, 1'b1, 8'h00, 8'hE7);
        chk(rdata_o == 8'hE7, "R11", "read after reset recovery", rdata_o, 8'hE7);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule